// File: doc/BRIEF.md
# Register-Programmed Burst Master

This block drives a Wishbone master port from a handful of settings held in a register file that is reached through a Wishbone slave port. Software programs a per-transaction beat count, a direction bit and a starting byte address. It then writes a transaction count, and that write launches the run. The engine issues that many equal-length block transactions back to back. Each transaction begins at the byte address where the previous one stopped. Write data for the master port is taken from a local word buffer. Read data returned on the master port is stored into the same buffer. Software reaches the buffer through the slave port when address bit 12 is clear.

A running tally of acknowledged master-port beats can be read and cleared through the register file. The remaining-transaction register shows how far a run has progressed. The burst hint (CAB) tells the downstream slave that more than one beat follows. It is raised only for multi-beat transactions.

The sequencer moves through three named states. SEQ_IDLE goes to SEQ_BURST on an accepted start. SEQ_BURST stays put while beats remain and goes to SEQ_GAP when the last beat of a transaction is acknowledged. SEQ_GAP returns to SEQ_BURST when transactions remain and to SEQ_IDLE when none do.

Top module: `wbm_burst_engine`

## Requirements
- R1: Slave-port decode looks only at address bits 12:0. Bit 12 set selects the register file, with word index taken from bits 11:2, so 0x0000_1xxx and 0xFFFF_Fxxx reach the same register. Bit 12 clear selects buffer word adr[7:2].
- R2: The beat-count register (index 0, byte offset 0x000) holds 11 bits, and its upper read bits are always zero.
- R3: The direction register (index 2, offset 0x008) holds bit 0. A 1 makes the master port write and a 0 makes it read. All other bits read zero.
- R4: The base-address register (index 3, offset 0x00C) always reads with bits 1:0 zero.
- R5: A write to index 1 (offset 0x004) starts a run only when the engine is idle and both the written 11-bit count and the beat count are nonzero. Otherwise the write has no effect.
- R6: Transaction k starts at base + k*beats*4, and the address advances by 4 after each acknowledged beat.
- R7: CAB is high throughout a transaction whose beat count exceeds 1, and low at all other times.
- R8: Index 9 (offset 0x024) reads the number of acknowledged master beats. Writing 0xFFFF_FFFF clears it, and a clear wins over a same-cycle beat. Any other written value leaves it unchanged.
- R9: CYC and STB stay high with a stable address until ACK. No idle cycle is inserted inside a transaction, and CYC is low for exactly one clock between transactions.
- R10: Index 1 reads the transactions still to run, including the current one, and reads zero when idle.
- R11: In write mode, beat n of a run (counted from 0 across the whole run) sends buffer word n mod 64. In read mode it stores the returned word there, and that store wins over a same-cycle slave write.
- R12: The slave port acknowledges each access with a one-cycle ACK in the clock after it is accepted, with read data valid alongside. Unmapped register indices read zero. Reset clears all registers, the buffer and both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_cyc | input | 1 | Slave-port cycle |
| s_stb | input | 1 | Slave-port strobe |
| s_we | input | 1 | Slave-port write enable |
| s_adr | input | 32 | Slave-port byte address |
| s_wdat | input | 32 | Slave-port write data |
| s_rdat | output | 32 | Slave-port read data |
| s_ack | output | 1 | Slave-port acknowledge |
| m_cyc | output | 1 | Master-port cycle |
| m_stb | output | 1 | Master-port strobe |
| m_we | output | 1 | Master-port write enable |
| m_cab | output | 1 | Master-port burst hint |
| m_adr | output | 32 | Master-port byte address |
| m_wdat | output | 32 | Master-port write data |
| m_rdat | input | 32 | Master-port read data |
| m_ack | input | 1 | Master-port acknowledge |

## Verification
The bench builds the engine with its default parameters: 32-bit address and data, an 11-bit beat and transaction width, and a 64-word buffer. A 40-beat, three-transaction run pushes the beat index past 64, which exercises the buffer-index wrap. Single-beat runs and a zero beat count reach the CAB and start-refusal corners. A slave responder that withholds ACK on every third cycle exercises the hold-until-acknowledge rule, and a counter clear issued during a live run exercises clear priority.

// File: rtl/wbm_pkg.sv
`timescale 1ns/1ps
package wbm_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BURST = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;

    localparam int REG_IDX_W  = 10;
    localparam int REG_BEATS  = 0;
    localparam int REG_COUNT  = 1;
    localparam int REG_DIR    = 2;
    localparam int REG_BASE   = 3;
    localparam int REG_TALLY  = 9;
endpackage

// File: rtl/wbm_word_buf.sv
`timescale 1ns/1ps
module wbm_word_buf #(
    parameter int DW  = 32,
    parameter int BAW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           m_we,
    input  logic [BAW-1:0] m_idx,
    input  logic [DW-1:0]  m_wdat,
    output logic [DW-1:0]  m_rdat,
    input  logic           s_we,
    input  logic [BAW-1:0] s_idx,
    input  logic [DW-1:0]  s_wdat,
    output logic [DW-1:0]  s_rdat
);
    localparam int DEPTH = 1 << BAW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '0;
            end else if (m_we && m_idx == BAW'(w)) begin
                mem[w] <= m_wdat;
            end else if (s_we && s_idx == BAW'(w)) begin
                mem[w] <= s_wdat;
            end
        end
    end

    assign m_rdat = mem[m_idx];
    assign s_rdat = mem[s_idx];
endmodule

// File: rtl/wbm_regfile.sv
`timescale 1ns/1ps
module wbm_regfile
    import wbm_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SW  = 11,
    parameter int BAW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           s_cyc,
    input  logic           s_stb,
    input  logic           s_we,
    input  logic [AW-1:0]  s_adr,
    input  logic [DW-1:0]  s_wdat,
    output logic [DW-1:0]  s_rdat,
    output logic           s_ack,
    input  logic           seq_idle,
    input  logic [SW-1:0]  seq_txn_left,
    input  logic           beat_ack,
    input  logic [DW-1:0]  buf_rdat,
    output logic [SW-1:0]  beats_q,
    output logic           dir_q,
    output logic [AW-1:0]  base_q,
    output logic           start,
    output logic [SW-1:0]  start_cnt,
    output logic           buf_swe,
    output logic [BAW-1:0] buf_sidx
);
    logic                 ack_q;
    logic                 accept;
    logic                 reg_sel;
    logic [REG_IDX_W-1:0] idx;
    logic                 reg_wr;
    logic                 tally_clr;
    logic [DW-1:0]        tally_q;
    logic [DW-1:0]        rd_mux;
    logic                 unused_adr;

    assign unused_adr = ^{s_adr[AW-1:13], s_adr[1:0]};

    assign accept    = s_cyc && s_stb && !ack_q;
    assign reg_sel   = s_adr[12];
    assign idx       = s_adr[11:2];
    assign reg_wr    = accept && s_we && reg_sel;
    assign tally_clr = reg_wr && idx == REG_IDX_W'(REG_TALLY) && s_wdat == '1;
    assign start_cnt = s_wdat[SW-1:0];
    assign start     = reg_wr && idx == REG_IDX_W'(REG_COUNT) && seq_idle
                       && beats_q != '0 && start_cnt != '0;
    assign buf_swe   = accept && s_we && !reg_sel;
    assign buf_sidx  = s_adr[2 +: BAW];

    always_comb begin
        rd_mux = '0;
        if (!reg_sel) begin
            rd_mux = buf_rdat;
        end else begin
            case (idx)
                REG_IDX_W'(REG_BEATS): rd_mux = DW'(beats_q);
                REG_IDX_W'(REG_COUNT): rd_mux = DW'(seq_txn_left);
                REG_IDX_W'(REG_DIR):   rd_mux = DW'(dir_q);
                REG_IDX_W'(REG_BASE):  rd_mux = DW'(base_q);
                REG_IDX_W'(REG_TALLY): rd_mux = tally_q;
                default:               rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            s_rdat  <= '0;
            beats_q <= '0;
            dir_q   <= 1'b0;
            base_q  <= '0;
            tally_q <= '0;
        end else begin
            ack_q <= accept;
            if (accept) begin
                s_rdat <= rd_mux;
            end
            if (reg_wr && idx == REG_IDX_W'(REG_BEATS)) begin
                beats_q <= s_wdat[SW-1:0];
            end
            if (reg_wr && idx == REG_IDX_W'(REG_DIR)) begin
                dir_q <= s_wdat[0];
            end
            if (reg_wr && idx == REG_IDX_W'(REG_BASE)) begin
                base_q <= s_wdat[AW-1:0] & ~AW'(3);
            end
            if (tally_clr) begin
                tally_q <= '0;
            end else if (beat_ack) begin
                tally_q <= tally_q + DW'(1);
            end
        end
    end

    assign s_ack = ack_q;

    // R8: every acknowledged beat not overridden by a clear bumps the tally
    a_r8_tally_step: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && !tally_clr) |=> (tally_q == $past(tally_q) + DW'(1)));

    // R8: a clear always leaves zero
    a_r8_tally_clear: assert property (@(posedge clk) disable iff (rst)
        tally_clr |=> (tally_q == '0));

    // R12: slave acknowledge is a single-cycle pulse
    a_r12_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        s_ack |=> !s_ack);

    // R4: base address never holds low bits
    a_r4_base_align: assert property (@(posedge clk) disable iff (rst)
        base_q[1:0] == 2'b00);
endmodule

// File: rtl/wbm_burst_seq.sv
`timescale 1ns/1ps
module wbm_burst_seq
    import wbm_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 11,
    parameter int BAW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [SW-1:0]  start_cnt,
    input  logic [SW-1:0]  beats_q,
    input  logic           dir_q,
    input  logic [AW-1:0]  base_q,
    input  logic           m_ack,
    output logic           m_cyc,
    output logic           m_stb,
    output logic           m_we,
    output logic           m_cab,
    output logic [AW-1:0]  m_adr,
    output logic [SW-1:0]  txn_left,
    output logic           idle,
    output logic           beat_ack,
    output logic [BAW-1:0] beat_idx
);
    localparam logic [AW-1:0] STRIDE = AW'(4);

    seq_state_e     state_q;
    seq_state_e     state_d;
    logic [SW-1:0]  beats_left;
    logic [SW-1:0]  run_beats;
    logic           run_dir;
    logic [AW-1:0]  adr_q;
    logic           last_beat;

    assign last_beat = beats_left == SW'(1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_BURST;
            SEQ_BURST: if (m_ack && last_beat) state_d = SEQ_GAP;
            SEQ_GAP:   state_d = (txn_left == '0) ? SEQ_IDLE : SEQ_BURST;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // Run datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            txn_left   <= '0;
            beats_left <= '0;
            run_beats  <= '0;
            run_dir    <= 1'b0;
            adr_q      <= '0;
            beat_idx   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        txn_left   <= start_cnt;
                        beats_left <= beats_q;
                        run_beats  <= beats_q;
                        run_dir    <= dir_q;
                        adr_q      <= base_q;
                        beat_idx   <= '0;
                    end
                end
                SEQ_BURST: begin
                    if (m_ack) begin
                        adr_q    <= adr_q + STRIDE;
                        beat_idx <= beat_idx + BAW'(1);
                        if (last_beat) txn_left   <= txn_left - SW'(1);
                        else           beats_left <= beats_left - SW'(1);
                    end
                end
                SEQ_GAP: beats_left <= run_beats;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        m_cyc    = 1'b0;
        m_stb    = 1'b0;
        m_cab    = 1'b0;
        m_we     = 1'b0;
        idle     = 1'b0;
        beat_ack = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  idle = 1'b1;
            SEQ_BURST: begin
                m_cyc    = 1'b1;
                m_stb    = 1'b1;
                m_we     = run_dir;
                m_cab    = run_beats > SW'(1);
                beat_ack = m_ack;
            end
            SEQ_GAP:   ;
            default:   ;
        endcase
    end

    assign m_adr = adr_q;

    // R9: strobe and address held until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (m_stb && !m_ack) |=> (m_stb && $stable(m_adr)));

    // R9: last beat of a transaction is followed by a low cycle
    a_r9_gap_after_txn: assert property (@(posedge clk) disable iff (rst)
        (m_stb && m_ack && last_beat) |=> !m_cyc);

    // R6: address advances by four after a mid-transaction beat
    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (m_stb && m_ack && !last_beat) |=> (m_adr == $past(m_adr) + STRIDE));

    // R10: nothing remains while idle
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        idle |-> (txn_left == '0));

    // R7: burst hint never outside a cycle
    a_r7_cab_in_cycle: assert property (@(posedge clk) disable iff (rst)
        m_cab |-> m_cyc);
endmodule

// File: rtl/wbm_burst_engine.sv
`timescale 1ns/1ps
module wbm_burst_engine #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SW  = 11,
    parameter int BAW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_cyc,
    input  logic          s_stb,
    input  logic          s_we,
    input  logic [AW-1:0] s_adr,
    input  logic [DW-1:0] s_wdat,
    output logic [DW-1:0] s_rdat,
    output logic          s_ack,
    output logic          m_cyc,
    output logic          m_stb,
    output logic          m_we,
    output logic          m_cab,
    output logic [AW-1:0] m_adr,
    output logic [DW-1:0] m_wdat,
    input  logic [DW-1:0] m_rdat,
    input  logic          m_ack
);
    logic           seq_idle;
    logic [SW-1:0]  txn_left;
    logic           beat_ack;
    logic [BAW-1:0] beat_idx;
    logic [DW-1:0]  buf_srdat;
    logic [SW-1:0]  beats_q;
    logic           dir_q;
    logic [AW-1:0]  base_q;
    logic           start;
    logic [SW-1:0]  start_cnt;
    logic           buf_swe;
    logic [BAW-1:0] buf_sidx;
    logic           buf_mwe;

    assign buf_mwe = beat_ack && !m_we;

    wbm_regfile #(.AW(AW), .DW(DW), .SW(SW), .BAW(BAW)) u_regs (
        .clk(clk), .rst(rst),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_wdat(s_wdat), .s_rdat(s_rdat), .s_ack(s_ack),
        .seq_idle(seq_idle), .seq_txn_left(txn_left), .beat_ack(beat_ack),
        .buf_rdat(buf_srdat), .beats_q(beats_q), .dir_q(dir_q),
        .base_q(base_q), .start(start), .start_cnt(start_cnt),
        .buf_swe(buf_swe), .buf_sidx(buf_sidx)
    );

    wbm_burst_seq #(.AW(AW), .SW(SW), .BAW(BAW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_cnt(start_cnt),
        .beats_q(beats_q), .dir_q(dir_q), .base_q(base_q), .m_ack(m_ack),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_cab(m_cab),
        .m_adr(m_adr), .txn_left(txn_left), .idle(seq_idle),
        .beat_ack(beat_ack), .beat_idx(beat_idx)
    );

    wbm_word_buf #(.DW(DW), .BAW(BAW)) u_buf (
        .clk(clk), .rst(rst),
        .m_we(buf_mwe), .m_idx(beat_idx), .m_wdat(m_rdat), .m_rdat(m_wdat),
        .s_we(buf_swe), .s_idx(buf_sidx), .s_wdat(s_wdat), .s_rdat(buf_srdat)
    );
endmodule

// File: tb/sim_wbm_burst_engine.sv
`timescale 1ns/1ps
module sim_wbm_burst_engine;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_cyc = 1'b0, s_stb = 1'b0, s_we = 1'b0;
    logic [31:0] s_adr = '0, s_wdat = '0;
    logic [31:0] s_rdat;
    logic        s_ack;
    logic        m_cyc, m_stb, m_we, m_cab;
    logic [31:0] m_adr, m_wdat;
    logic [31:0] m_rdat = '0;
    logic        m_ack = 1'b0;

    always #5 clk = ~clk;

    wbm_burst_engine u0 (
        .clk(clk), .rst(rst), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we),
        .s_adr(s_adr), .s_wdat(s_wdat), .s_rdat(s_rdat), .s_ack(s_ack),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_cab(m_cab),
        .m_adr(m_adr), .m_wdat(m_wdat), .m_rdat(m_rdat), .m_ack(m_ack)
    );

    int checks = 0;
    int fails  = 0;
    int cyc_n  = 0;
    int ack_mode = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int          md_state;   // 0 idle, 1 burst, 2 gap
    int          md_txn, md_beats, md_run_beats, md_bidx;
    bit          md_run_dir, md_dir, md_sack;
    logic [31:0] md_beatsreg, md_base, md_adr, md_tally, md_srdat;
    logic [31:0] mbuf [DEPTH];

    always @(posedge clk) begin : model
        bit          acc, mack, clr, strt;
        int          ix;
        logic [31:0] rd;
        if (rst) begin
            md_state = 0; md_txn = 0; md_beats = 0; md_run_beats = 0; md_bidx = 0;
            md_run_dir = 0; md_dir = 0; md_sack = 0; md_beatsreg = 0; md_base = 0;
            md_adr = 0; md_tally = 0; md_srdat = 0;
            for (int k = 0; k < DEPTH; k++) mbuf[k] = 0;
        end else begin
            acc  = s_cyc && s_stb && !md_sack;
            mack = (md_state == 1) && m_ack;
            ix   = int'(s_adr[11:2]);
            rd   = 0;
            if (acc) begin
                if (!s_adr[12]) rd = mbuf[s_adr[7:2]];
                else if (ix == 0) rd = md_beatsreg;
                else if (ix == 1) rd = md_txn;
                else if (ix == 2) rd = {31'b0, md_dir};
                else if (ix == 3) rd = md_base;
                else if (ix == 9) rd = md_tally;
                md_srdat = rd;
            end
            md_sack = acc;
            clr  = acc && s_we && s_adr[12] && ix == 9 && s_wdat == 32'hFFFF_FFFF;
            strt = acc && s_we && s_adr[12] && ix == 1 && md_state == 0
                   && md_beatsreg != 0 && s_wdat[10:0] != 0;
            if (clr) md_tally = 0;
            else if (mack) md_tally = md_tally + 1;
            if (acc && s_we && s_adr[12]) begin
                if (ix == 0) md_beatsreg = {21'b0, s_wdat[10:0]};
                if (ix == 2) md_dir = s_wdat[0];
                if (ix == 3) md_base = {s_wdat[31:2], 2'b00};
            end
            if (acc && s_we && !s_adr[12]) mbuf[s_adr[7:2]] = s_wdat;
            if (mack && !md_run_dir) mbuf[md_bidx % DEPTH] = m_rdat;
            case (md_state)
                0: if (strt) begin
                    md_state = 1; md_txn = int'(s_wdat[10:0]);
                    md_beats = int'(md_beatsreg); md_run_beats = md_beats;
                    md_run_dir = md_dir; md_adr = md_base; md_bidx = 0;
                end
                1: if (mack) begin
                    md_adr = md_adr + 4; md_bidx = md_bidx + 1;
                    if (md_beats == 1) begin md_txn = md_txn - 1; md_state = 2; end
                    else md_beats = md_beats - 1;
                end
                default: begin
                    md_beats = md_run_beats;
                    md_state = (md_txn == 0) ? 0 : 1;
                end
            endcase
        end
    end

    // Per-cycle comparison and master-port responder
    always @(negedge clk) begin : compare_respond
        cyc_n++;
        if (!rst) begin
            check("R9 cyc", {31'b0, m_cyc}, {31'b0, md_state == 1});
            check("R9 stb", {31'b0, m_stb}, {31'b0, md_state == 1});
            check("R7 cab", {31'b0, m_cab}, {31'b0, md_state == 1 && md_run_beats > 1});
            if (md_state == 1) begin
                check("R6 adr", m_adr, md_adr);
                check("R3 we", {31'b0, m_we}, {31'b0, md_run_dir});
                if (md_run_dir) check("R11 wdat", m_wdat, mbuf[md_bidx % DEPTH]);
            end
            check("R12 ack", {31'b0, s_ack}, {31'b0, md_sack});
            if (md_sack) check("R12 rdat", s_rdat, md_srdat);
        end
        m_ack  = m_cyc && m_stb && (ack_mode == 0 || (cyc_n % 3) != 1);
        m_rdat = 32'hC0DE_0000 ^ cyc_n;
    end

    task automatic bus(input logic we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        s_cyc = 1; s_stb = 1; s_we = we; s_adr = a; s_wdat = d;
        @(negedge clk);
        r = s_rdat;
        s_cyc = 0; s_stb = 0; s_we = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] r;
        bus(1'b1, a, d, r);
    endtask

    task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] r;
        bus(1'b0, a, 32'h0, r);
        check(tag, r, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int k = 0; k < 3000; k++) begin
            bus(1'b0, 32'h0000_1004, 32'h0, r);
            if (r == 0) break;
        end
        check("R10 count idle", r, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R12 reset cyc", {31'b0, m_cyc}, 32'h0);
        check("R12 reset ack", {31'b0, s_ack}, 32'h0);
        rd_chk("R12 reset tally", 32'h0000_1024, 32'h0);

        // R1/R2: alias and width
        wr(32'h0000_1000, 32'hFFFF_F805);
        rd_chk("R2 beats upper zero", 32'hFFFF_F000, 32'h0000_0005);
        wr(32'hFFFF_F008, 32'hFFFF_FFFF);
        rd_chk("R3 dir bit only", 32'h0000_1008, 32'h1);
        wr(32'h0000_100C, 32'h0000_0103);
        rd_chk("R4 base aligned", 32'hFFFF_F00C, 32'h0000_0100);
        rd_chk("R12 unmapped zero", 32'h0000_1010, 32'h0);

        // R11/R1: buffer fill through both aliases
        for (int k = 0; k < DEPTH; k++) wr(32'h0000_0000 + 32'(k * 4), 32'h1111_0000 + 32'(k));
        rd_chk("R1 buffer alias", 32'hFFFF_E008, 32'h1111_0002);

        // R5/R6/R10: 3 x 5-beat write run
        wr(32'h0000_1004, 32'h3);
        rd_chk("R10 count running", 32'h0000_1004, 32'h3);
        wr(32'h0000_1004, 32'h7);           // R5: ignored while busy
        wait_idle();
        rd_chk("R8 tally 15", 32'h0000_1024, 32'd15);
        wr(32'h0000_1024, 32'h1);
        rd_chk("R8 partial write no clear", 32'h0000_1024, 32'd15);
        wr(32'h0000_1024, 32'hFFFF_FFFF);
        rd_chk("R8 cleared", 32'h0000_1024, 32'h0);

        // R7/R11: 4 single-beat reads, stalled ack
        ack_mode = 1;
        wr(32'h0000_1000, 32'h1);
        wr(32'h0000_1008, 32'h0);
        wr(32'h0000_1004, 32'h4);
        wait_idle();
        rd_chk("R8 tally 4", 32'h0000_1024, 32'd4);
        bus(1'b0, 32'h0000_0004, 32'h0, r);
        check("R11 read stored", {31'b0, r[31:16] == 16'hC0DE}, 32'h1);

        // R5: zero beat count refuses start
        wr(32'h0000_1000, 32'h0);
        wr(32'h0000_1004, 32'h2);
        repeat (3) @(negedge clk);
        check("R5 no start", {31'b0, m_cyc}, 32'h0);
        rd_chk("R5 count zero", 32'h0000_1004, 32'h0);

        // R11 wrap: 3 x 40-beat writes
        wr(32'h0000_1024, 32'hFFFF_FFFF);
        wr(32'h0000_1000, 32'd40);
        wr(32'h0000_1008, 32'h1);
        wr(32'h0000_100C, 32'h0000_8000);
        wr(32'h0000_1004, 32'h3);
        wait_idle();
        rd_chk("R8 tally 120", 32'h0000_1024, 32'd120);

        // R8: clear during a live run
        ack_mode = 0;
        wr(32'h0000_1000, 32'd8);
        wr(32'h0000_1004, 32'h2);
        wr(32'h0000_1024, 32'hFFFF_FFFF);
        wait_idle();
        bus(1'b0, 32'h0000_1024, 32'h0, r);
        check("R8 clear mid-run", {31'b0, r < 32'd16}, 32'h1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule